// File: doc/BRIEF.md
# Owner-Locked Line Memory with Fixed Access Latency

This block is a backing store organized as lines of four words. A requester presents an operation together with its identifier. Three operations are supported: writing one word, reading a whole line, and writing a whole line at once. The whole-line write is the path a cache uses to push out a dirty line. Every operation takes a fixed, parameterized number of cycles. The store serves one requester at a time.

The first requester to present an operation to an idle store takes ownership. The operation code, address and data are captured at that moment. A countdown then runs. The owner keeps presenting its request and receives a wait response until the countdown reaches its last cycle; in that cycle it receives ok and ownership is released. A requester whose identifier differs from the owner's receives wait and cannot change the store. With a latency of zero or one, an operation completes in the cycle it is presented.

Top module: `linemem_owner`

## Requirements
- R1: An address splits into a line index (address divided by 4, upper bits) and a word index (address modulo 4, low two bits). A word write (operation code 0) changes only the addressed word of the addressed line.
- R2: A line read (operation code 1) at any of the four word addresses of a line returns the whole line.
- R3: With LATENCY set to 0, every operation asserts resp_ok in the same cycle it is presented, and a word written in one cycle is visible to a read in the next.
- R4: With LATENCY = L of at least 2, resp_wait is high for the first L-1 consecutive cycles of a presented operation and resp_ok is high in the L-th cycle. Writing a full line one word at a time therefore takes 4L cycles, and resp_ok is never high in two consecutive cycles.
- R5: While an operation is in progress, a request carrying a different identifier receives resp_wait, never resp_ok, and leaves the stored data unchanged.
- R6: A line write (operation code 2) replaces all four words of the addressed line in one operation. It uses the same lock and the same latency as a line read and leaves other lines unchanged.
- R7: After reset, every stored word reads as zero.
- R8: resp_wait is high exactly when req_valid is high and resp_ok is low. With req_valid low, both responses are low.
- R9: resp_line carries word k at bits [32k+31:32k]. It is zero in every cycle other than the ok cycle of a line read.
- R10: The operation code, address and data are captured when an operation is accepted. Changes the owner makes to them while waiting are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request is being presented this cycle |
| req_id | input | ID_W (2) | Identifier of the presenting requester |
| req_op | input | 2 | 0 word write, 1 line read, 2 line write, 3 no access |
| req_addr | input | ADDR_W (6) | Word address |
| req_wdata | input | WORD_W (32) | Data for a word write |
| req_wline | input | LINE_W (128) | Data for a line write, word k at bits [32k+31:32k] |
| resp_ok | output | 1 | Operation completes this cycle |
| resp_wait | output | 1 | Request presented but not completed this cycle |
| resp_line | output | LINE_W (128) | Line read data, valid with resp_ok of a line read |

## Verification
The bench builds two copies of the block side by side. The first uses LATENCY 3, which makes the wait cycles, the contention between two identifiers, the capture of the request at acceptance and the 12-cycle four-word fill observable. The second uses LATENCY 0, which exercises the variant without a counter, where every operation completes in its own cycle and a write is visible on the next read. Both copies use 16 lines, so neighbouring lines can be checked for unwanted changes.

// File: rtl/lm_pkg.sv
package lm_pkg;
   typedef enum logic [1:0] {
      LM_WORD_WR = 2'd0,
      LM_LINE_RD = 2'd1,
      LM_LINE_WR = 2'd2,
      LM_NO_ACC  = 2'd3
   } lm_op_e;
endpackage

// File: rtl/lm_lock_timer.sv
module lm_lock_timer #(
   parameter int ID_W    = 2,
   parameter int LATENCY = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [ID_W-1:0] req_id,
   output logic            accept,
   output logic            done,
   output logic            busy,
   output logic [ID_W-1:0] owner
);
   generate
      if (LATENCY <= 1) begin : g_direct
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign accept = req_valid;
         assign done   = req_valid;
         assign busy   = 1'b0;
         assign owner  = req_id;
      end else begin : g_count
         localparam int CNT_W = $clog2(LATENCY + 1);
         logic             busy_q;
         logic [ID_W-1:0]  owner_q;
         logic [CNT_W-1:0] cnt_q;

         assign accept = req_valid && !busy_q;
         assign done   = busy_q && req_valid && (req_id == owner_q)
                         && (cnt_q == CNT_W'(1));
         assign busy   = busy_q;
         assign owner  = owner_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q  <= 1'b0;
               owner_q <= '0;
               cnt_q   <= '0;
            end else if (accept) begin
               busy_q  <= 1'b1;
               owner_q <= req_id;
               cnt_q   <= CNT_W'(LATENCY - 1);
            end else if (done) begin
               busy_q  <= 1'b0;
            end else if (busy_q && (cnt_q > CNT_W'(1))) begin
               cnt_q   <= cnt_q - CNT_W'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lm_line_store.sv
module lm_line_store #(
   parameter int WORD_W         = 32,
   parameter int WORDS_PER_LINE = 4,
   parameter int NUM_LINES      = 16,
   localparam int OFF_W  = $clog2(WORDS_PER_LINE),
   localparam int LIDX_W = $clog2(NUM_LINES),
   localparam int LINE_W = WORD_W * WORDS_PER_LINE,
   localparam int NWORDS = NUM_LINES * WORDS_PER_LINE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_word,
   input  logic              wr_line,
   input  logic [LIDX_W-1:0] line_idx,
   input  logic [OFF_W-1:0]  word_idx,
   input  logic [WORD_W-1:0] wdata,
   input  logic [LINE_W-1:0] wline,
   output logic [LINE_W-1:0] rd_line
);
   logic [WORD_W-1:0] words [NWORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NWORDS; i++) words[i] <= '0;
      end else begin
         for (int l = 0; l < NUM_LINES; l++) begin
            for (int w = 0; w < WORDS_PER_LINE; w++) begin
               if (wr_line && (line_idx == LIDX_W'(l)))
                  words[l*WORDS_PER_LINE + w] <= wline[w*WORD_W +: WORD_W];
               else if (wr_word && (line_idx == LIDX_W'(l)) && (word_idx == OFF_W'(w)))
                  words[l*WORDS_PER_LINE + w] <= wdata;
            end
         end
      end
   end

   generate
      for (genvar w = 0; w < WORDS_PER_LINE; w++) begin : g_lane
         assign rd_line[w*WORD_W +: WORD_W] = words[{line_idx, OFF_W'(w)}];
      end
   endgenerate
endmodule

// File: rtl/linemem_owner.sv
module linemem_owner #(
   parameter int WORD_W         = 32,
   parameter int WORDS_PER_LINE = 4,
   parameter int NUM_LINES      = 16,
   parameter int ID_W           = 2,
   parameter int LATENCY        = 3,
   localparam int LINE_W = WORD_W * WORDS_PER_LINE,
   localparam int OFF_W  = $clog2(WORDS_PER_LINE),
   localparam int LIDX_W = $clog2(NUM_LINES),
   localparam int ADDR_W = LIDX_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ID_W-1:0]   req_id,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   input  logic [LINE_W-1:0] req_wline,
   output logic              resp_ok,
   output logic              resp_wait,
   output logic [LINE_W-1:0] resp_line
);
   import lm_pkg::*;

   generate
      if (WORDS_PER_LINE < 2 || (1 << OFF_W) != WORDS_PER_LINE) begin : g_bad_wpl
         $error("WORDS_PER_LINE must be a power of two of at least 2");
      end
      if (NUM_LINES < 2 || (1 << LIDX_W) != NUM_LINES) begin : g_bad_lines
         $error("NUM_LINES must be a power of two of at least 2");
      end
      if (LATENCY < 0) begin : g_bad_lat
         $error("LATENCY must not be negative");
      end
      if (ID_W < 1 || WORD_W < 1) begin : g_bad_w
         $error("ID_W and WORD_W must be positive");
      end
   endgenerate

   logic            lock_accept, lock_done, lock_busy;
   logic [ID_W-1:0] lock_owner;

   lm_lock_timer #(.ID_W(ID_W), .LATENCY(LATENCY)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_id    (req_id),
      .accept    (lock_accept),
      .done      (lock_done),
      .busy      (lock_busy),
      .owner     (lock_owner)
   );

   lm_op_e            cap_op;
   logic [ADDR_W-1:0] cap_addr;
   logic [WORD_W-1:0] cap_wdata;
   logic [LINE_W-1:0] cap_wline;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_op    <= LM_NO_ACC;
         cap_addr  <= '0;
         cap_wdata <= '0;
         cap_wline <= '0;
      end else if (lock_accept) begin
         cap_op    <= lm_op_e'(req_op);
         cap_addr  <= req_addr;
         cap_wdata <= req_wdata;
         cap_wline <= req_wline;
      end
   end

   lm_op_e            eff_op;
   logic [ADDR_W-1:0] eff_addr;
   logic [WORD_W-1:0] eff_wdata;
   logic [LINE_W-1:0] eff_wline;
   logic [LINE_W-1:0] store_line;

   always_comb begin
      if (lock_busy) begin
         eff_op    = cap_op;
         eff_addr  = cap_addr;
         eff_wdata = cap_wdata;
         eff_wline = cap_wline;
      end else begin
         eff_op    = lm_op_e'(req_op);
         eff_addr  = req_addr;
         eff_wdata = req_wdata;
         eff_wline = req_wline;
      end
   end

   lm_line_store #(
      .WORD_W(WORD_W), .WORDS_PER_LINE(WORDS_PER_LINE), .NUM_LINES(NUM_LINES)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_word  (lock_done && (eff_op == LM_WORD_WR)),
      .wr_line  (lock_done && (eff_op == LM_LINE_WR)),
      .line_idx (eff_addr[ADDR_W-1:OFF_W]),
      .word_idx (eff_addr[OFF_W-1:0]),
      .wdata    (eff_wdata),
      .wline    (eff_wline),
      .rd_line  (store_line)
   );

   assign resp_ok   = lock_done;
   assign resp_wait = req_valid && !lock_done;
   assign resp_line = (lock_done && (eff_op == LM_LINE_RD)) ? store_line : '0;
endmodule

// File: rtl/lm_checker.sv
module lm_checker #(
   parameter int ID_W    = 2,
   parameter int LINE_W  = 128,
   parameter int LATENCY = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ID_W-1:0]   req_id,
   input logic              resp_ok,
   input logic              resp_wait,
   input logic [LINE_W-1:0] resp_line,
   input logic              busy,
   input logic [ID_W-1:0]   owner
);
   assert_ok_wait_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(resp_ok && resp_wait));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!resp_ok && !resp_wait));

   assert_line_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_line != '0) |-> resp_ok);

   assert_foreign_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid && (req_id != owner)) |-> (resp_wait && !resp_ok));

   generate
      if (LATENCY >= 2) begin : g_timed
         assert_no_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
            resp_ok |=> !resp_ok);

         assert_owner_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && !resp_ok) |=> (busy && (owner == $past(owner))));
      end
   endgenerate
endmodule

bind linemem_owner lm_checker #(.ID_W(ID_W), .LINE_W(LINE_W), .LATENCY(LATENCY)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_id    (req_id),
   .resp_ok   (resp_ok),
   .resp_wait (resp_wait),
   .resp_line (resp_line),
   .busy      (lock_busy),
   .owner     (lock_owner)
);

// File: tb/linemem_owner_bench.sv
`timescale 1ns/100ps
module linemem_owner_bench;
   localparam logic [1:0] OP_WW = 2'd0, OP_RD = 2'd1, OP_LW = 2'd2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic         req_valid = 1'b0;
   logic [1:0]   req_id = '0, req_op = '0;
   logic [5:0]   req_addr = '0;
   logic [31:0]  req_wdata = '0;
   logic [127:0] req_wline = '0;
   logic         resp_ok, resp_wait;
   logic [127:0] resp_line;

   logic         z_valid = 1'b0;
   logic [1:0]   z_op = '0;
   logic [5:0]   z_addr = '0;
   logic [31:0]  z_wdata = '0;
   logic         z_ok, z_wait;
   logic [127:0] z_line;

   linemem_owner u_linemem_owner (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_wline(req_wline), .resp_ok(resp_ok), .resp_wait(resp_wait),
      .resp_line(resp_line));

   linemem_owner #(.LATENCY(0)) u_linemem_owner_lat0 (
      .clk(clk), .rst_n(rst_n), .req_valid(z_valid), .req_id(2'd0),
      .req_op(z_op), .req_addr(z_addr), .req_wdata(z_wdata),
      .req_wline(128'd0), .resp_ok(z_ok), .resp_wait(z_wait),
      .resp_line(z_line));

   int n_chk = 0, n_fail = 0;
   logic [31:0] model [64];

   task automatic check_eq(input string req, input string what,
                           input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [127:0] mline(input logic [5:0] a);
      logic [5:0] b = {a[5:2], 2'b00};
      return {model[b+3], model[b+2], model[b+1], model[b]};
   endfunction

   task automatic run_op(input logic [1:0] op, input logic [1:0] id, input logic [5:0] a,
                         input logic [31:0] wd, input logic [127:0] wl,
                         output int cyc, output logic [127:0] line);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_id = id; req_addr = a;
      req_wdata = wd; req_wline = wl;
      cyc = 0; line = '0;
      while (1) begin
         #1;
         cyc++;
         if (resp_ok) begin line = resp_line; break; end
         if (cyc > 50) break;
         @(negedge clk);
      end
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   // {op, addr, data}
   localparam logic [39:0] TBL [8] = '{
      {OP_WW, 6'h00, 32'h11223311},
      {OP_WW, 6'h01, 32'h11223312},
      {OP_WW, 6'h02, 32'h11223313},
      {OP_WW, 6'h03, 32'h11223314},
      {OP_RD, 6'h00, 32'h0},
      {OP_RD, 6'h03, 32'h0},
      {OP_WW, 6'h25, 32'hA5A50025},
      {OP_RD, 6'h26, 32'h0}
   };

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int cyc, fill;
      logic [127:0] line, wl;
      for (int i = 0; i < 64; i++) model[i] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // Reset state and idle quiet outputs
      @(negedge clk); #1;
      check_eq("R8", "ok idle", {127'd0, resp_ok}, 128'd0);
      check_eq("R8", "wait idle", {127'd0, resp_wait}, 128'd0);
      check_eq("R9", "line idle", resp_line, 128'd0);
      run_op(OP_RD, 2'd0, 6'h3F, 32'h0, 128'h0, cyc, line);
      check_eq("R7", "line after reset", line, 128'd0);

      // Table walk
      fill = 0;
      for (int i = 0; i < 8; i++) begin
         logic [1:0] op = TBL[i][39:38];
         logic [5:0] a = TBL[i][37:32];
         run_op(op, 2'd1, a, TBL[i][31:0], 128'h0, cyc, line);
         check_eq("R4", $sformatf("cycles entry %0d", i), 128'(cyc), 128'd3);
         if (i < 4) fill += cyc;
         if (op == OP_WW) model[a] = TBL[i][31:0];
         else check_eq("R2", $sformatf("line entry %0d (R1 word split)", i), line, mline(a));
      end
      check_eq("R4", "four-word fill cycles", 128'(fill), 128'd12);

      // Contention and capture: id0 owns, id1 intrudes, id0 alters its request
      @(negedge clk);
      req_valid = 1'b1; req_id = 2'd0; req_op = OP_WW; req_addr = 6'h10; req_wdata = 32'hDEAD0010;
      #1 check_eq("R4", "wait first cycle", {126'd0, resp_wait, resp_ok}, 128'd2);
      @(negedge clk);
      req_id = 2'd1; req_addr = 6'h14; req_wdata = 32'hBAD00014;
      #1 check_eq("R5", "foreign id waits", {126'd0, resp_wait, resp_ok}, 128'd2);
      @(negedge clk);
      req_id = 2'd0; req_addr = 6'h11; req_wdata = 32'h11111111;
      #1 check_eq("R4", "ok third cycle", {126'd0, resp_wait, resp_ok}, 128'd1);
      @(posedge clk); #1 req_valid = 1'b0;
      model[6'h10] = 32'hDEAD0010;
      run_op(OP_RD, 2'd2, 6'h11, 32'h0, 128'h0, cyc, line);
      check_eq("R10", "captured address and data", line, mline(6'h10));
      run_op(OP_RD, 2'd2, 6'h14, 32'h0, 128'h0, cyc, line);
      check_eq("R5", "foreign write had no effect", line, 128'd0);

      // Read output gated during wait cycles
      @(negedge clk);
      req_valid = 1'b1; req_id = 2'd3; req_op = OP_RD; req_addr = 6'h02;
      #1 check_eq("R9", "line zero while waiting", resp_line, 128'd0);
      @(negedge clk); @(negedge clk);
      #1 check_eq("R9", "line in ok cycle", resp_line, mline(6'h00));
      @(posedge clk); #1 req_valid = 1'b0;

      // Line write, eviction path
      wl = {32'hC0DE0003, 32'hC0DE0002, 32'hC0DE0001, 32'hC0DE0000};
      run_op(OP_LW, 2'd2, 6'h09, 32'h0, wl, cyc, line);
      check_eq("R6", "line write cycles", 128'(cyc), 128'd3);
      for (int k = 0; k < 4; k++) model[8+k] = wl[k*32 +: 32];
      run_op(OP_RD, 2'd0, 6'h0B, 32'h0, 128'h0, cyc, line);
      check_eq("R6", "line write content", line, wl);
      run_op(OP_LW, 2'd1, 6'h02, 32'h0, ~wl, cyc, line);
      for (int k = 0; k < 4; k++) model[k] = ~wl[k*32 +: 32];
      run_op(OP_RD, 2'd1, 6'h01, 32'h0, 128'h0, cyc, line);
      check_eq("R6", "overwrite of filled line", line, ~wl);
      run_op(OP_RD, 2'd1, 6'h08, 32'h0, 128'h0, cyc, line);
      check_eq("R6", "neighbour line unchanged", line, mline(6'h08));

      // Zero-latency variant
      @(negedge clk);
      z_valid = 1'b1; z_op = OP_RD; z_addr = 6'h07;
      #1 check_eq("R3", "read ok same cycle", {126'd0, z_wait, z_ok}, 128'd1);
      check_eq("R7", "lat0 line after reset", z_line, 128'd0);
      @(negedge clk);
      z_op = OP_WW; z_addr = 6'h06; z_wdata = 32'h600D0006;
      #1 check_eq("R3", "write ok same cycle", {126'd0, z_wait, z_ok}, 128'd1);
      @(negedge clk);
      z_op = OP_RD; z_addr = 6'h04;
      #1 check_eq("R1", "word 2 lands at bits 95:64", z_line,
                  {32'h0, 32'h600D0006, 64'h0});
      @(negedge clk);
      z_valid = 1'b0;
      #1 check_eq("R8", "lat0 idle quiet", {126'd0, z_wait, z_ok}, 128'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule